// File: doc/BRIEF.md
# Sequential Signed Shift-and-Add Multiplier

This block multiplies two signed operands of `W` bits and returns a signed product of `2W` bits. It does not build signed partial products. When a start pulse arrives, it records the sign of the result, converts each operand to its unsigned magnitude, and then runs one add-and-shift step per clock for `W` clocks into a double-width accumulator. One final clock negates the accumulator if the recorded sign is negative and writes the registered product.

To use it, the caller drives the operands and pulses `start` while `busy` is low. `busy` stays high while the loop runs. `done` then pulses for one cycle, and `product` holds the result until the next accepted start. The operands are sampled only in the start cycle.

Top module: `smag_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` pulse sampled while `busy` is 0 makes `busy` 1 from the next cycle.
- R3: `done` is 1 for exactly one cycle. It becomes visible W+1 rising edges after the edge that accepted `start`. `busy` is 0 in that cycle and `done` is never 1 together with `busy`.
- R4: `product` equals the two's-complement product of `mcand` and `mplier` sampled at the accepting edge, for every combination of operand signs.
- R5: A most-negative operand (only bit W-1 set) is multiplied as magnitude 2^(W-1), and the product is correct. This includes the case where both operands are most-negative, giving +2^(2W-2).
- R6: A `start` pulse while `busy` is 1 is ignored. It does not change the result, the operands used or the completion time of the running operation.
- R7: `product` changes only in a cycle where `done` is 1. Between operations it holds its last value.
- R8: When either operand is zero, the product is zero with no negative-zero artifact, whatever the other operand's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product, held until the next completion |

## Verification
A dropped carry out of the high-half addition, or a wrong shift into the low half, corrupts only products whose partial sums overflow W bits. Such a fault shows at `product` on the completion pulse of large-magnitude operands, so most-negative and near-full-scale operands are exercised. A missed sign correction or a wrong sign XOR flips the result of mixed-sign cases at the same pulse. An iteration counter that is off by one moves `done` away from edge W+1, which the bench counts directly. A start that is wrongly accepted while busy shows as a changed result or a shifted completion.

// File: rtl/smag_mult.sv
module smag_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIX} st_t;
  st_t st;

  logic [W-1:0]  xq, yq, hi, lo;
  logic          neg;
  logic [CW-1:0] cnt;

  wire [W-1:0]   amag = mcand[W-1]  ? (~mcand + 1'b1)  : mcand;
  wire [W-1:0]   bmag = mplier[W-1] ? (~mplier + 1'b1) : mplier;
  wire [W:0]     sum  = {1'b0, hi} + {1'b0, (yq[0] ? xq : {W{1'b0}})};
  wire [2*W-1:0] acc  = {hi, lo};

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      xq      <= '0;
      yq      <= '0;
      hi      <= '0;
      lo      <= '0;
      neg     <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          xq  <= amag;
          yq  <= bmag;
          hi  <= '0;
          lo  <= '0;
          neg <= mcand[W-1] ^ mplier[W-1];
          cnt <= '0;
          st  <= RUN;
        end
        RUN: begin
          hi  <= sum[W:1];
          lo  <= {sum[0], lo[W-1:1]};
          yq  <= yq >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= FIX;
        end
        FIX: begin
          product <= neg ? (~acc + 1'b1) : acc;
          done    <= 1'b1;
          st      <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module smag_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && done) |-> $past(busy));

  // R7
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !done) |-> $stable(product));
endmodule

bind smag_mult smag_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/smag_mult_tb.sv
module smag_mult_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smag_mult #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  // run one op; optional ignored start with other operands at cycle ign_at
  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input int ign_at);
    int n;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk({req, " R2 busy"}, 64'(busy), 64'd1);
    n = 0;
    while (n < 4*W) begin
      @(posedge clk); #1;
      n++;
      if (done) break;
      if (n == ign_at) begin
        mcand = ~a; mplier = b + 8'd3; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n++;
        if (done) break;
      end
    end
    chk({req, " R3 latency"}, 64'(n), 64'(W + 1));
    chk({req, " R3 busy low"}, 64'(busy), 64'd0);
    chk({req, " R4 product"}, 64'(product), 64'(exp));
    @(posedge clk); #1;
    chk({req, " R3 one-cycle"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 product", 64'(product), 64'd0);
  endtask

  task automatic t_signs();
    run_op("R4 6x5", 8'd6, 8'd5, 0);
    run_op("R4 -7x9", 8'hF9, 8'd9, 0);
    run_op("R4 13x-11", 8'd13, 8'hF5, 0);
    run_op("R4 -100x-3", 8'h9C, 8'hFD, 0);
    run_op("R4 127x127", 8'd127, 8'd127, 0);
  endtask

  task automatic t_minneg();
    run_op("R5 -128x-128", 8'h80, 8'h80, 0);
    run_op("R5 -128x127", 8'h80, 8'd127, 0);
    run_op("R5 -1x-128", 8'hFF, 8'h80, 0);
  endtask

  task automatic t_zero();
    run_op("R8 0x-5", 8'd0, 8'hFB, 0);
    run_op("R8 -128x0", 8'h80, 8'd0, 0);
  endtask

  task automatic t_ignore();
    run_op("R6 busy start", 8'hE3, 8'd77, 3);
  endtask

  task automatic t_hold();
    logic [2*W-1:0] p;
    run_op("R7 setup", 8'd50, 8'hF0, 0);
    p = product;
    mcand = 8'd1; mplier = 8'd1;
    repeat (6) @(posedge clk);
    #1;
    chk("R7 hold", 64'(product), 64'(p));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_signs();
    t_minneg();
    t_zero();
    t_ignore();
    t_hold();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule